// File: doc/BRIEF.md
# Adjustable Precision Time Counter

This block keeps a free-running nanosecond count for IEEE 1588 timestamping. Software reaches it through a small 32-bit register bus: byte address, write enable, write data and combinational read data. While counting is enabled, each clock adds a programmable nominal increment. A correction increment can replace the nominal one on every N-th counting cycle. By pairing a correction increment slightly above or below the nominal with a chosen N, software sets the average rate in fine steps without changing the clock.

Software can load the count directly, clear it, and freeze a snapshot of it for a consistent readback. The count can wrap at a programmable period, which gives a time base of arbitrary range, for example 2^31 ns. A single-cycle strobe from the packet datapath copies the live count into a read-only timestamp register.

Top module: `ptp_time_ctr`

## Requirements
- R1: After reset the count, every register and every read value are zero.
- R2: The control register at offset 0x00 holds the enable in bit 0. While the enable is 1, the count grows each clock by the nominal increment, which is bits [6:0] of the increment register at 0x10. While the enable is 0, the count holds.
- R3: The correction period P is held in the register at 0x0C. When P is nonzero, every P-th counting cycle adds the correction increment, bits [14:8] of the increment register, in place of the nominal one. Only cycles that advance the count move the correction phase.
- R4: A correction period of zero turns correction off, so only the nominal increment is added.
- R5: A write to the correction period register, a write to the time register, or a restart sets the correction phase back to its start. The cycle that carries the write still uses the old phase and the old period.
- R6: A write to the time register at 0x04 loads the count with the written value. Counting resumes from that value on the following cycle.
- R7: Writing 1 to control bit 9 sets the count to zero in place of that cycle's advance. Control bit 9 and control bit 11 always read back as 0. Only bits 0 and 4 of the control register read back.
- R8: Writing 1 to control bit 11 copies the count as it stood before that write into a snapshot. A read of 0x04 returns the snapshot and not the running count.
- R9: When control bit 4 is set and the wrap period W at 0x08 is nonzero, an advance whose sum reaches W or more stores the sum minus W. When W is zero, no wrap takes place.
- R10: A one-cycle pulse on the strobe input copies the count as it stood before that edge into the timestamp register at 0x14. Writes to that register are ignored.
- R11: A read of the increment register returns the nominal increment in bits [6:0] and the correction increment in bits [14:8], with every other bit 0. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| we_i | input | 1 | Write strobe for the register at addr_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| stamp_i | input | 1 | Strobe that latches the count into the timestamp register |
| time_o | output | 32 | Live count |

## Verification
The bench targets the cycle in which a correction lands. A design with an off-by-one phase counter would shift every correction by one cycle, and a design that kept the old phase after a period write would apply a correction early. It checks that a wrap stores the overshoot above the period, where a design that forced the count to zero would lose nanoseconds. It also checks that the snapshot and the timestamp hold the count from before the edge and do not follow the running value afterwards. Finally, it writes junk to the read-only timestamp register and to the reserved increment bits, and confirms that neither write is visible.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_TIME  = 'h04;
  localparam int unsigned OFS_WRAP  = 'h08;
  localparam int unsigned OFS_CPER  = 'h0C;
  localparam int unsigned OFS_INC   = 'h10;
  localparam int unsigned OFS_STAMP = 'h14;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_WRAP    = 4;
  localparam int unsigned BIT_RESTART = 9;
  localparam int unsigned BIT_CAPTURE = 11;

  localparam int unsigned INC_CORR_LSB = 8;

  typedef struct packed {
    logic wrap_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned INC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              stamp_i,
  output ctrl_t             ctrl_o,
  output logic [INC_W-1:0]  nom_inc_o,
  output logic [INC_W-1:0]  corr_inc_o,
  output logic [DATA_W-1:0] corr_per_o,
  output logic [DATA_W-1:0] wrap_per_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              restart_o,
  output logic              phase_clr_o
);
  logic sel_ctrl, sel_time, sel_wrap, sel_cper, sel_inc, sel_stamp;
  logic capture;
  ctrl_t ctrl_q;
  logic [INC_W-1:0]  nom_q, corr_q;
  logic [DATA_W-1:0] cper_q, wper_q, snap_q, stamp_q;

  assign sel_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_time  = (addr_i == ADDR_W'(OFS_TIME));
  assign sel_wrap  = (addr_i == ADDR_W'(OFS_WRAP));
  assign sel_cper  = (addr_i == ADDR_W'(OFS_CPER));
  assign sel_inc   = (addr_i == ADDR_W'(OFS_INC));
  assign sel_stamp = (addr_i == ADDR_W'(OFS_STAMP));

  // restart and capture are strobes, never stored
  assign restart_o   = we_i & sel_ctrl & wdata_i[BIT_RESTART];
  assign capture     = we_i & sel_ctrl & wdata_i[BIT_CAPTURE];
  assign load_o      = we_i & sel_time;
  assign load_val_o  = wdata_i;
  assign phase_clr_o = we_i & sel_cper;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      nom_q  <= '0;
      corr_q <= '0;
      cper_q <= '0;
      wper_q <= '0;
      snap_q <= '0;
    end else begin
      if (we_i && sel_ctrl) begin
        ctrl_q.en      <= wdata_i[BIT_EN];
        ctrl_q.wrap_en <= wdata_i[BIT_WRAP];
      end
      if (we_i && sel_inc) begin
        nom_q  <= wdata_i[INC_W-1:0];
        corr_q <= wdata_i[INC_CORR_LSB +: INC_W];
      end
      if (we_i && sel_cper) cper_q <= wdata_i;
      if (we_i && sel_wrap) wper_q <= wdata_i;
      if (capture)          snap_q <= cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stamp_q <= '0;
    else if (stamp_i) stamp_q <= cnt_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: begin
        rdata_o[BIT_EN]   = ctrl_q.en;
        rdata_o[BIT_WRAP] = ctrl_q.wrap_en;
      end
      sel_time:  rdata_o = snap_q;
      sel_wrap:  rdata_o = wper_q;
      sel_cper:  rdata_o = cper_q;
      sel_inc: begin
        rdata_o[INC_W-1:0]              = nom_q;
        rdata_o[INC_CORR_LSB +: INC_W]  = corr_q;
      end
      sel_stamp: rdata_o = stamp_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign nom_inc_o  = nom_q;
  assign corr_inc_o = corr_q;
  assign corr_per_o = cper_q;
  assign wrap_per_o = wper_q;

  a_r10_stamp_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stamp_i |=> stamp_q == $past(cnt_i));
  a_r8_snap_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> snap_q == $past(cnt_i));
  a_r10_stamp_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stamp_i |=> $stable(stamp_q));
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [INC_W-1:0]  nom_i,
  input  logic [INC_W-1:0]  corr_i,
  output logic [INC_W-1:0]  inc_o
);
  logic [DATA_W-1:0] phase_q;
  logic              hit;

  assign hit   = step_i && (period_i != '0) && (phase_q == period_i - 1'b1);
  assign inc_o = hit ? corr_i : nom_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (hit)    phase_q <= '0;
    else if (step_i) phase_q <= phase_q + 1'b1;
  end

  a_r4_no_corr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> inc_o == nom_i);
  a_r3_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i != '0) |-> phase_q < period_i);
  a_r5_phase_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0);
endmodule

// File: rtl/ptp_tc_count.sv
module ptp_tc_count #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              wrap_en_i,
  input  logic [DATA_W-1:0] wrap_per_i,
  output logic [DATA_W-1:0] cnt_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] cnt_q, adv;
  logic [SUM_W-1:0]  sum, over;
  logic              wrap;

  assign sum  = {1'b0, cnt_q} + SUM_W'(inc_i);
  assign wrap = wrap_en_i && (wrap_per_i != '0) && (sum >= {1'b0, wrap_per_i});
  assign over = sum - {1'b0, wrap_per_i};
  assign adv  = wrap ? over[DATA_W-1:0] : sum[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (step_i)    cnt_q <= adv;
  end

  assign cnt_o = cnt_q;

  a_r7_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  a_r6_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !restart_i) |=> cnt_q == $past(load_val_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !restart_i) |=> $stable(cnt_q));
  a_r9_stays_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !restart_i && wrap_en_i && wrap_per_i != '0 &&
     cnt_q < wrap_per_i && DATA_W'(inc_i) < wrap_per_i)
    |=> cnt_q < $past(wrap_per_i));
endmodule

// File: rtl/ptp_time_ctr.sv
module ptp_time_ctr
  import ptp_tc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned INC_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              stamp_i,
  output logic [DATA_W-1:0] time_o
);
  ctrl_t             ctrl;
  logic [INC_W-1:0]  nom_inc, corr_inc, inc;
  logic [DATA_W-1:0] corr_per, wrap_per, load_val, cnt;
  logic              load, restart, phase_clr, step;

  ptp_tc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .stamp_i, .ctrl_o(ctrl),
    .nom_inc_o(nom_inc), .corr_inc_o(corr_inc),
    .corr_per_o(corr_per), .wrap_per_o(wrap_per),
    .load_o(load), .load_val_o(load_val),
    .restart_o(restart), .phase_clr_o(phase_clr)
  );

  assign step = ctrl.en & ~load & ~restart;

  ptp_tc_rate #(.DATA_W(DATA_W), .INC_W(INC_W)) u_rate (
    .clk_i, .rst_ni, .step_i(step),
    .clr_i(phase_clr | load | restart),
    .period_i(corr_per), .nom_i(nom_inc), .corr_i(corr_inc), .inc_o(inc)
  );

  ptp_tc_count #(.DATA_W(DATA_W), .INC_W(INC_W)) u_count (
    .clk_i, .rst_ni, .step_i(step), .load_i(load), .restart_i(restart),
    .load_val_i(load_val), .inc_i(inc),
    .wrap_en_i(ctrl.wrap_en), .wrap_per_i(wrap_per), .cnt_o(cnt)
  );

  assign time_o = cnt;

  a_r2_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en && !we_i) |=> $stable(time_o));
endmodule

// File: tb/sim_ptp_time_ctr.sv
`timescale 1ns/1ps
module sim_ptp_time_ctr;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, strobe = 1'b0;
  logic [31:0] wdata = '0, rdata, time_v;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptp_time_ctr u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .stamp_i(strobe), .time_o(time_v));

  // reference model built from the requirements
  logic [31:0] m_cnt, m_snap, m_stamp, m_cper, m_wper, m_ph;
  logic        m_en, m_wen;
  logic [6:0]  m_nom, m_corr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_snap <= 0; m_stamp <= 0; m_cper <= 0; m_wper <= 0;
      m_ph <= 0; m_en <= 0; m_wen <= 0; m_nom <= 0; m_corr <= 0;
    end else begin : mdl
      logic rs, ld, cl, st, hit;
      logic [6:0] inc;
      logic [32:0] sum;
      rs = we && addr == 8'h00 && wdata[9];
      ld = we && addr == 8'h04;
      cl = we && addr == 8'h0C;
      st = m_en && !rs && !ld;
      hit = st && m_cper != 0 && m_ph == m_cper - 1;
      inc = hit ? m_corr : m_nom;
      sum = {1'b0, m_cnt} + 33'(inc);
      if (m_wen && m_wper != 0 && sum >= {1'b0, m_wper}) sum = sum - {1'b0, m_wper};
      if (rs) m_cnt <= 0;
      else if (ld) m_cnt <= wdata;
      else if (st) m_cnt <= sum[31:0];
      if (cl || ld || rs || hit) m_ph <= 0;
      else if (st) m_ph <= m_ph + 1;
      if (we && addr == 8'h00) begin
        m_en <= wdata[0]; m_wen <= wdata[4];
        if (wdata[11]) m_snap <= m_cnt;
      end
      if (we && addr == 8'h08) m_wper <= wdata;
      if (cl) m_cper <= wdata;
      if (we && addr == 8'h10) begin m_nom <= wdata[6:0]; m_corr <= wdata[14:8]; end
      if (strobe) m_stamp <= m_cnt;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {27'd0, m_wen, 3'd0, m_en};
      8'h04: return m_snap;
      8'h08: return m_wper;
      8'h0C: return m_cper;
      8'h10: return {17'd0, m_corr, 1'b0, m_nom};
      8'h14: return m_stamp;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00: return "R7";
      8'h04: return "R8";
      8'h14: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin : main
    logic [31:0] t;
    void'($urandom(32'd1588));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", time_v, 0);
    for (int a = 0; a < 7; a++) rd(8'(a * 4), 0, "R1");
    // R11 reserved increment bits dropped, R3 correction every 4th cycle
    wr(8'h10, 32'hFFFF_8905);
    rd(8'h10, 32'h0000_0905, "R11");
    rd(8'h18, 0, "R11");
    wr(8'h0C, 4);
    wr(8'h00, 1);
    check("R2", time_v, 0);
    repeat (8) @(negedge clk);
    check("R3", time_v, 48);
    // R7 restart
    wr(8'h00, 32'h201);
    check("R7", time_v, 0);
    rd(8'h00, 1, "R7");
    repeat (4) @(negedge clk);
    check("R3", time_v, 24);
    // R4 correction disabled
    wr(8'h0C, 0);
    repeat (6) @(negedge clk);
    check("R4", time_v, 59);
    // R6 load
    wr(8'h04, 1000);
    repeat (2) @(negedge clk);
    check("R6", time_v, 1010);
    // R9 wrap keeps overshoot
    wr(8'h08, 1020);
    wr(8'h00, 32'h11);
    check("R9", time_v, 1020);
    @(negedge clk);
    check("R9", time_v, 5);
    // R8 capture
    wr(8'h00, 32'h811);
    rd(8'h04, 5, "R8");
    check("R8", time_v, 10);
    // R5 phase restarts on period write
    wr(8'h0C, 3);
    check("R5", time_v, 15);
    repeat (3) @(negedge clk);
    check("R5", time_v, 34);
    // R10 timestamp
    t = time_v;
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    rd(8'h14, t, "R10");
    wr(8'h14, 32'hDEAD_BEEF);
    rd(8'h14, t, "R10");
    // R2 disabled hold
    wr(8'h00, 0);
    t = time_v;
    repeat (5) @(negedge clk);
    check("R2", time_v, t);

    // random phase against the reference model
    for (int i = 0; i < 4000; i++) begin
      int op;
      check("R2", time_v, m_cnt);
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: begin
          logic [7:0] a;
          a = 8'($urandom_range(0, 7) * 4);
          rd(a, exp_read(a), req_of(a));
        end
        3: begin
          logic [31:0] d;
          d = $urandom & 32'hFFFF_F5EE;
          d[0] = ($urandom_range(0, 7) != 0);
          d[9] = ($urandom_range(0, 7) == 0);
          d[11] = ($urandom_range(0, 3) == 0);
          addr = 8'h00; wdata = d; we = 1'b1;
        end
        4: begin addr = 8'h04; wdata = $urandom_range(0, 3000); we = 1'b1; end
        5: begin
          addr = 8'h08; we = 1'b1;
          wdata = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(500, 2000);
        end
        6: begin addr = 8'h0C; wdata = $urandom_range(0, 5); we = 1'b1; end
        7: begin addr = 8'h10; wdata = $urandom; we = 1'b1; end
        8: strobe = 1'b1;
        default: ;
      endcase
      @(negedge clk);
      we = 1'b0; strobe = 1'b0;
    end
    check("R2", time_v, m_cnt);
    finish_run();
  end
endmodule